// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns one long element-wise loop over three arrays (two source streams and one destination stream) into a series of vector commands that each fit in a vector register of at most 64 elements. Software or an issue stage hands it an element count and three byte base addresses in a single start handshake. The block then issues one chunk command at a time. Each command carries the vector length for that chunk and the current value of each pointer.

The short part of the loop goes first. The first chunk carries the count modulo 64, or a full 64 when the count is an exact multiple. Every later chunk carries the full 64 elements. When a chunk command is accepted, the block moves each pointer forward by the chunk length times the element size (8 bytes) and lowers the remaining count by the chunk length. After the last chunk is accepted, a done flag is raised for exactly one cycle. A zero count gives no chunk at all and only the done pulse.

Top module: `stripmine_seq`

## Requirements
- R1: `start_ready` is high exactly when no chunk command is pending. A start is accepted on a clock edge where both `start_valid` and `start_ready` are high.
- R2: The first chunk length is N mod 64 when that value is nonzero, and 64 when N is a nonzero multiple of 64.
- R3: Every chunk after the first carries length 64.
- R4: The first chunk carries the three base addresses unchanged. Each later chunk carries pointers that are larger by (previous chunk length × 8) than those of the previous chunk, taken modulo 2^32.
- R5: A nonzero N gives exactly ceil(N/64) chunk commands whose lengths add up to N. `cmd_valid` stays high from the cycle after start acceptance until the last chunk is accepted.
- R6: With N = 0, no chunk command is issued, and `done` is high in the cycle right after the start is accepted.
- R7: `done` is high for exactly one cycle, in the cycle right after the last chunk handshake. It is never high while a chunk is pending.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the length and all three pointers hold their values.
- R9: After reset, `cmd_valid` and `done` are low and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Block idle, start can be accepted |
| start_count | input | 16 | Total element count N |
| start_src_a | input | 32 | Base byte address of the first source |
| start_src_b | input | 32 | Base byte address of the second source |
| start_dst | input | 32 | Base byte address of the destination |
| cmd_valid | output | 1 | Chunk command pending |
| cmd_ready | input | 1 | Consumer accepts the chunk |
| cmd_len | output | 7 | Chunk vector length, 1..64 |
| cmd_src_a | output | 32 | Current first-source pointer |
| cmd_src_b | output | 32 | Current second-source pointer |
| cmd_dst | output | 32 | Current destination pointer |
| done | output | 1 | One-cycle pulse when the whole loop has been issued |

## Verification
The assertions assume two things. The consumer may hold `cmd_ready` low for any number of cycles, but it does eventually accept. Start fields are sampled only on the accepting edge. Beyond that they assume only the port protocol, so pointer wrap-around past 2^32 is legal and is checked. The stimulus raises `start_valid` only while `start_ready` is high and drops it after one accepting edge. It sweeps every count from 0 to 200 under three `cmd_ready` patterns: always ready, alternating, and one stall in three. It also runs a maximum count and a large exact multiple of 64. One destination base sits close enough to the top of the address space that it wraps.

// File: rtl/sm_pkg.sv
package sm_pkg;

   // sequencer state: waiting for a loop, or issuing chunks
   typedef enum logic [0:0] {
      SM_IDLE = 1'b0,
      SM_RUN  = 1'b1
   } sm_state_e;

   // true when v is a power of two and at least 2
   function automatic bit sm_is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sm_len_calc.sv
module sm_len_calc #(
   parameter int CNT_W = 16,
   parameter int MAXVL = 64,
   parameter int LEN_W = $clog2(MAXVL) + 1
) (
   input  logic             first,
   input  logic [CNT_W-1:0] rem,
   output logic [LEN_W-1:0] len
);
   localparam int MOD_W = $clog2(MAXVL);
   localparam logic [LEN_W-1:0] FULL = LEN_W'(MAXVL);

   generate
      if (CNT_W > MOD_W) begin : g_wide
         // count may exceed one register: first chunk takes the remainder
         logic [MOD_W-1:0] low;
         assign low = rem[MOD_W-1:0];
         always_comb begin
            if (!first)          len = FULL;
            else if (low == '0)  len = FULL;
            else                 len = {{(LEN_W-MOD_W){1'b0}}, low};
         end
      end else begin : g_narrow
         // count always fits in one register: single chunk of rem elements
         logic unused_first;
         assign unused_first = first;
         assign len = LEN_W'(rem);
      end
   endgenerate
endmodule

// File: rtl/sm_ptr_bank.sv
module sm_ptr_bank #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 7,
   parameter int ELEM_BYTES = 8,
   parameter int NPTR       = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [NPTR-1:0][ADDR_W-1:0]  load_val,
   input  logic                         advance,
   input  logic [LEN_W-1:0]             len,
   output logic [NPTR-1:0][ADDR_W-1:0]  ptr
);
   logic [ADDR_W-1:0] step;

   generate
      if (sm_pkg::sm_is_pow2(ELEM_BYTES)) begin : g_shift
         localparam int SH = $clog2(ELEM_BYTES);
         assign step = ADDR_W'(len) << SH;
      end else begin : g_mult
         assign step = ADDR_W'(len) * ADDR_W'(ELEM_BYTES);
      end
   endgenerate

   generate
      for (genvar i = 0; i < NPTR; i++) begin : g_ptr
         always_ff @(posedge clk) begin
            if (!rst_n)        ptr[i] <= '0;
            else if (load)     ptr[i] <= load_val[i];
            else if (advance)  ptr[i] <= ptr[i] + step;
         end
      end
   endgenerate
endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl #(
   parameter int CNT_W = 16,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_valid,
   input  logic [CNT_W-1:0] start_count,
   output logic             start_ready,
   input  logic             cmd_ready,
   input  logic [LEN_W-1:0] len,
   output logic             run,
   output logic             first,
   output logic [CNT_W-1:0] rem,
   output logic             load,
   output logic             advance,
   output logic             done
);
   import sm_pkg::*;

   sm_state_e        state;
   logic             start_fire;
   logic             last;
   logic [CNT_W-1:0] len_c;

   assign len_c       = CNT_W'(len);
   assign run         = (state == SM_RUN);
   assign start_ready = (state == SM_IDLE);
   assign start_fire  = start_valid && start_ready;
   assign advance     = run && cmd_ready;
   assign load        = start_fire;
   assign last        = (rem == len_c);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SM_IDLE;
         rem   <= '0;
         first <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_fire) begin
            if (start_count == '0) begin
               done <= 1'b1;
            end else begin
               state <= SM_RUN;
               rem   <= start_count;
               first <= 1'b1;
            end
         end else if (advance) begin
            rem   <= rem - len_c;
            first <= 1'b0;
            if (last) begin
               state <= SM_IDLE;
               done  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/stripmine_seq.sv
module stripmine_seq #(
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 32,
   parameter int MAXVL      = 64,
   parameter int ELEM_BYTES = 8,
   parameter int LEN_W      = $clog2(MAXVL) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   output logic              start_ready,
   input  logic [CNT_W-1:0]  start_count,
   input  logic [ADDR_W-1:0] start_src_a,
   input  logic [ADDR_W-1:0] start_src_b,
   input  logic [ADDR_W-1:0] start_dst,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [LEN_W-1:0]  cmd_len,
   output logic [ADDR_W-1:0] cmd_src_a,
   output logic [ADDR_W-1:0] cmd_src_b,
   output logic [ADDR_W-1:0] cmd_dst,
   output logic              done
);
   localparam int NPTR = 3;

   generate
      if (!sm_pkg::sm_is_pow2(MAXVL)) begin : g_bad_maxvl
         $error("MAXVL must be a power of two, at least 2");
      end
      if (ELEM_BYTES < 1) begin : g_bad_elem
         $error("ELEM_BYTES must be positive");
      end
      if (LEN_W != $clog2(MAXVL) + 1) begin : g_bad_lenw
         $error("LEN_W must stay at its derived value");
      end
   endgenerate

   logic                        run, first, load, advance;
   logic [CNT_W-1:0]            rem;
   logic [NPTR-1:0][ADDR_W-1:0] base, ptr;

   assign base[0] = start_src_a;
   assign base[1] = start_src_b;
   assign base[2] = start_dst;

   sm_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_count(start_count),
      .start_ready(start_ready), .cmd_ready(cmd_ready), .len(cmd_len),
      .run(run), .first(first), .rem(rem), .load(load),
      .advance(advance), .done(done)
   );

   sm_len_calc #(.CNT_W(CNT_W), .MAXVL(MAXVL), .LEN_W(LEN_W)) u_len (
      .first(first), .rem(rem), .len(cmd_len)
   );

   sm_ptr_bank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ELEM_BYTES(ELEM_BYTES),
                 .NPTR(NPTR)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(base),
      .advance(advance), .len(cmd_len), .ptr(ptr)
   );

   assign cmd_valid = run;
   assign cmd_src_a = ptr[0];
   assign cmd_src_b = ptr[1];
   assign cmd_dst   = ptr[2];
endmodule

// File: rtl/stripmine_seq_chk.sv
module stripmine_seq_chk #(
   parameter int ADDR_W     = 32,
   parameter int MAXVL      = 64,
   parameter int ELEM_BYTES = 8,
   parameter int LEN_W      = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_ready,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [LEN_W-1:0]  cmd_len,
   input logic [ADDR_W-1:0] cmd_src_a,
   input logic [ADDR_W-1:0] cmd_src_b,
   input logic [ADDR_W-1:0] cmd_dst,
   input logic              done
);
   logic              fire_q;
   logic [ADDR_W-1:0] exp_a, exp_b, exp_d;
   logic [ADDR_W-1:0] bump;

   assign bump = ADDR_W'(cmd_len) * ADDR_W'(ELEM_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fire_q <= 1'b0;
         exp_a  <= '0;
         exp_b  <= '0;
         exp_d  <= '0;
      end else begin
         fire_q <= cmd_valid && cmd_ready;
         exp_a  <= cmd_src_a + bump;
         exp_b  <= cmd_src_b + bump;
         exp_d  <= cmd_dst + bump;
      end
   end

   p_idle_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_ready |-> !cmd_valid);

   p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_len != '0) && (cmd_len <= LEN_W'(MAXVL)));

   p_full_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (!cmd_valid || cmd_len == LEN_W'(MAXVL)));

   p_bump_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_q && cmd_valid) |->
         (cmd_src_a == exp_a && cmd_src_b == exp_b && cmd_dst == exp_d));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_len) && $stable(cmd_src_a) &&
          $stable(cmd_src_b) && $stable(cmd_dst)));

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!cmd_valid && start_ready));
endmodule

bind stripmine_seq stripmine_seq_chk #(
   .ADDR_W(ADDR_W), .MAXVL(MAXVL), .ELEM_BYTES(ELEM_BYTES), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_ready(start_ready),
   .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
   .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
   .done(done)
);

// File: tb/test_stripmine_seq.sv
module test_stripmine_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;
   localparam int ADDR_W = 32;
   localparam int MAXVL = 64;
   localparam int EB = 8;
   localparam int LEN_W = 7;

   logic clk = 1'b0;
   logic rst_n;
   logic start_valid, start_ready, cmd_valid, cmd_ready, done;
   logic [CNT_W-1:0]  start_count;
   logic [ADDR_W-1:0] start_src_a, start_src_b, start_dst;
   logic [LEN_W-1:0]  cmd_len;
   logic [ADDR_W-1:0] cmd_src_a, cmd_src_b, cmd_dst;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stripmine_seq i_stripmine_seq (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_ready(start_ready),
      .start_count(start_count), .start_src_a(start_src_a),
      .start_src_b(start_src_b), .start_dst(start_dst),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
      .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
      .done(done)
   );

   task automatic check(string req, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_case(int n, logic [31:0] a, logic [31:0] b,
                           logic [31:0] d, int mode);
      int rem = n;
      int idx = 0;
      int cyc = 0;
      int exp_len;
      bit stalled = 0;
      bit rdy;
      logic [31:0] pa = a, pb = b, pd = d;
      @(negedge clk);
      check("R1", "start_ready idle", longint'(start_ready), 1);
      start_valid = 1'b1;
      start_count = n[CNT_W-1:0];
      start_src_a = a; start_src_b = b; start_dst = d;
      @(negedge clk);
      start_valid = 1'b0;
      if (n == 0) begin
         check("R6", "done on zero count", longint'(done), 1);
         check("R6", "no chunk on zero count", longint'(cmd_valid), 0);
         @(negedge clk);
         check("R7", "done single cycle", longint'(done), 0);
         return;
      end
      while (rem > 0) begin
         check("R5", "cmd_valid while pending", longint'(cmd_valid), 1);
         check("R7", "no done while pending", longint'(done), 0);
         check("R1", "start_ready busy", longint'(start_ready), 0);
         exp_len = (idx == 0) ? ((n % MAXVL == 0) ? MAXVL : n % MAXVL) : MAXVL;
         check(stalled ? "R8" : (idx == 0 ? "R2" : "R3"), "cmd_len",
               longint'(cmd_len), exp_len);
         check(stalled ? "R8" : "R4", "src_a", longint'(cmd_src_a), longint'(pa));
         check(stalled ? "R8" : "R4", "src_b", longint'(cmd_src_b), longint'(pb));
         check(stalled ? "R8" : "R4", "dst", longint'(cmd_dst), longint'(pd));
         rdy = (mode == 0) ? 1'b1 : (((cyc + n + idx) % (mode + 1)) != 0);
         cmd_ready = rdy;
         @(negedge clk);
         cyc++;
         if (rdy) begin
            rem -= exp_len;
            idx++;
            pa += 32'(exp_len * EB);
            pb += 32'(exp_len * EB);
            pd += 32'(exp_len * EB);
            stalled = 0;
         end else begin
            stalled = 1;
         end
      end
      cmd_ready = 1'b0;
      check("R5", "chunk count", idx, (n + MAXVL - 1) / MAXVL);
      check("R5", "cmd_valid drops after last", longint'(cmd_valid), 0);
      check("R7", "done after last handshake", longint'(done), 1);
      @(negedge clk);
      check("R7", "done single cycle", longint'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      start_valid = 1'b0; cmd_ready = 1'b0;
      start_count = '0; start_src_a = '0; start_src_b = '0; start_dst = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "reset cmd_valid", longint'(cmd_valid), 0);
      check("R9", "reset done", longint'(done), 0);
      check("R9", "reset start_ready", longint'(start_ready), 1);
      for (int n = 0; n <= 200; n++) begin
         for (int m = 0; m < 3; m++) begin
            run_case(n, 32'h1000_0000 + 32'(n * 16), 32'h2000_0000 - 32'(n * 8),
                     32'hFFFF_FF00 + 32'(n), m);
         end
      end
      run_case(65535, 32'h0000_0040, 32'h8000_0000, 32'hFFFF_0000, 0);
      run_case(64 * 100, 32'h0001_0000, 32'h0002_0000, 32'h0003_0000, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule